// File: doc/BRIEF.md
# Masked Variable Arithmetic Vector Shifter

This unit takes a packed vector and shifts each of its lanes right arithmetically, each lane by its own amount. The vacated upper bits take the sign of that lane. Per operation, the lanes can be 16, 32 or 64 bits wide, and the active vector can be 128, 256 or 512 bits long. The shift amount for a lane comes from the same lane of a second vector. For 32-bit and 64-bit lanes it can instead come from one scalar that is applied to every lane. An amount at or above the lane width fills the lane with its sign bit. Because of this, a large count never wraps around to a small shift.

A per-lane writemask can be enabled. A lane whose mask bit is clear either keeps the matching lane of an old-destination input (merging) or is cleared (zeroing). Every output bit above the active vector length is zero. Some control combinations are not supported. For these the unit raises an error flag and returns an all-zero vector. The result is registered once, so it appears one clock after the operands are presented.

Top module: `vsra_unit`

## Requirements
- R1: With a count below the lane width, a lane's result equals the source lane shifted right by the count, with the vacated high bits copied from the lane's bit of highest order.
- R2: The whole count lane is read as an unsigned number. Any value at or above the lane width (16, 32 or 64) makes every bit of the result lane equal to the source lane's sign bit. For example, a 16-bit count of 0x8001 gives a full fill.
- R3: The lane width is chosen by elem_sel: 0 gives 16 bits, 1 gives 32 bits, 2 gives 64 bits. The active length is chosen by vl_sel: 0 gives 128 bits, 1 gives 256 bits, 2 gives 512 bits. Lane j occupies bits [j*W+W-1 : j*W].
- R4: With mask_en=1 and zeroing=0, a lane inside the active length whose mask bit j is 0 outputs old_dst for that lane.
- R5: With mask_en=1 and zeroing=1, a lane inside the active length whose mask bit j is 0 outputs zero.
- R6: With mask_en=0, every lane inside the active length is shifted, and mask and zeroing have no effect.
- R7: All dst bits at or above the active length are zero. Mask bits and old_dst bits that belong to lanes beyond the active length have no effect.
- R8: With bcst_en=1, src2 is ignored. For 32-bit lanes, bits [31:0] of bcst_scalar give the count for every lane, and its upper half is ignored. For 64-bit lanes, all 64 bits of bcst_scalar give the count.
- R9: elem_sel=3, vl_sel=3, or bcst_en=1 with 16-bit lanes sets err=1 with dst all zero. Every other combination gives err=0.
- R10: dst and err update on the rising clock edge after the operands are applied. While rst_n is low, dst and err are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src1 | input | 512 | Vector to be shifted |
| src2 | input | 512 | Per-lane shift counts |
| bcst_scalar | input | 64 | Count shared by all lanes when broadcasting |
| old_dst | input | 512 | Lane values kept by merging |
| mask | input | 32 | Per-lane writemask, bit j gates lane j |
| elem_sel | input | 2 | Lane width select |
| vl_sel | input | 2 | Active vector length select |
| mask_en | input | 1 | Writemask enable |
| zeroing | input | 1 | 1 clears masked-off lanes, 0 merges them |
| bcst_en | input | 1 | Use bcst_scalar as the count for all lanes |
| dst | output | 512 | Result vector |
| err | output | 1 | Unsupported control combination |

## Verification
Two functions can meet in one lane in the same cycle: the sign fill caused by an oversized count, and the writemask. When both apply, the mask must decide the lane, so the result is the old value or zero and never the fill. Stimulus rows combine all-ones counts with partial masks, in both merging and zeroing mode. Every lane is compared with an independent bit-level model. Broadcast combined with merging is exercised the same way. A directed case also combines a set mask bit with the boundary of the active length, to show that bits above the length stay zero.

// File: rtl/vsra_pkg.sv
package vsra_pkg;

    typedef enum logic [1:0] {
        EW_16  = 2'd0,
        EW_32  = 2'd1,
        EW_64  = 2'd2,
        EW_BAD = 2'd3
    } elem_e;

    typedef enum logic [1:0] {
        VL_128 = 2'd0,
        VL_256 = 2'd1,
        VL_512 = 2'd2,
        VL_BAD = 2'd3
    } vlen_e;

    localparam int VMAX_DEF  = 512;
    localparam int MIN_EW    = 16;
    localparam int SCALAR_W  = 64;
    localparam int N_WIDTHS  = 3;

endpackage

// File: rtl/vsra_decode.sv
module vsra_decode
    import vsra_pkg::*;
#(
    parameter int VB_W = 10
) (
    input  logic [1:0]      elem_sel,
    input  logic [1:0]      vl_sel,
    input  logic            bcst_en,
    output logic            bad,
    output logic [VB_W-1:0] vl_bits
);

    elem_e ew;
    vlen_e vl;

    always_comb begin
        ew = elem_e'(elem_sel);
        vl = vlen_e'(vl_sel);
        bad = (ew == EW_BAD) || (vl == VL_BAD) || (bcst_en && ew == EW_16);
        unique case (vl)
            VL_128:  vl_bits = VB_W'(128);
            VL_256:  vl_bits = VB_W'(256);
            VL_512:  vl_bits = VB_W'(512);
            default: vl_bits = '0;
        endcase
    end

endmodule

// File: rtl/vsra_lane.sv
module vsra_lane #(
    parameter int EW = 32
) (
    input  logic [EW-1:0] src,
    input  logic [EW-1:0] cnt,
    output logic [EW-1:0] res
);

    localparam int SH_W = $clog2(EW);

    logic over;

    always_comb begin
        over = (cnt > EW'(EW - 1));
        if (over) begin
            res = {EW{src[EW-1]}};
        end else begin
            res = EW'($signed(src) >>> cnt[SH_W-1:0]);
        end
    end

endmodule

// File: rtl/vsra_slice.sv
module vsra_slice #(
    parameter int VMAX = 512,
    parameter int EW   = 32,
    parameter int VB_W = 10,
    localparam int NL  = VMAX / EW
) (
    input  logic [VMAX-1:0] src1,
    input  logic [VMAX-1:0] src2,
    input  logic [VMAX-1:0] old_dst,
    input  logic [EW-1:0]   scalar,
    input  logic [NL-1:0]   mask,
    input  logic [VB_W-1:0] vl_bits,
    input  logic            mask_en,
    input  logic            zeroing,
    input  logic            bcst_en,
    output logic [VMAX-1:0] res
);

    for (genvar j = 0; j < NL; j++) begin : g_lane
        logic [EW-1:0] cnt;
        logic [EW-1:0] shifted;
        logic          in_vl;
        logic          take;

        assign cnt   = bcst_en ? scalar : src2[j*EW +: EW];
        assign in_vl = VB_W'(j * EW) < vl_bits;
        assign take  = !mask_en || mask[j];

        vsra_lane #(.EW(EW)) i_lane (
            .src (src1[j*EW +: EW]),
            .cnt (cnt),
            .res (shifted)
        );

        always_comb begin
            if (!in_vl) begin
                res[j*EW +: EW] = '0;
            end else if (take) begin
                res[j*EW +: EW] = shifted;
            end else if (zeroing) begin
                res[j*EW +: EW] = '0;
            end else begin
                res[j*EW +: EW] = old_dst[j*EW +: EW];
            end
        end
    end

endmodule

// File: rtl/vsra_unit.sv
module vsra_unit
    import vsra_pkg::*;
#(
    parameter int VMAX    = VMAX_DEF,
    parameter bit OUT_REG = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [VMAX-1:0]     src1,
    input  logic [VMAX-1:0]     src2,
    input  logic [SCALAR_W-1:0] bcst_scalar,
    input  logic [VMAX-1:0]     old_dst,
    input  logic [VMAX/MIN_EW-1:0] mask,
    input  logic [1:0]          elem_sel,
    input  logic [1:0]          vl_sel,
    input  logic                mask_en,
    input  logic                zeroing,
    input  logic                bcst_en,
    output logic [VMAX-1:0]     dst,
    output logic                err
);

    localparam int VB_W = $clog2(VMAX) + 1;

    logic            bad;
    logic [VB_W-1:0] vl_bits;
    logic [VMAX-1:0] cand [N_WIDTHS];
    logic [VMAX-1:0] dst_d;

    vsra_decode #(.VB_W(VB_W)) i_decode (
        .elem_sel (elem_sel),
        .vl_sel   (vl_sel),
        .bcst_en  (bcst_en),
        .bad      (bad),
        .vl_bits  (vl_bits)
    );

    for (genvar k = 0; k < N_WIDTHS; k++) begin : g_width
        localparam int EW = MIN_EW << k;
        localparam int NL = VMAX / EW;

        vsra_slice #(.VMAX(VMAX), .EW(EW), .VB_W(VB_W)) i_slice (
            .src1    (src1),
            .src2    (src2),
            .old_dst (old_dst),
            .scalar  (bcst_scalar[EW-1:0]),
            .mask    (mask[NL-1:0]),
            .vl_bits (vl_bits),
            .mask_en (mask_en),
            .zeroing (zeroing),
            .bcst_en (bcst_en),
            .res     (cand[k])
        );
    end

    always_comb begin
        dst_d = '0;
        if (!bad) begin
            unique case (elem_e'(elem_sel))
                EW_16:   dst_d = cand[0];
                EW_32:   dst_d = cand[1];
                EW_64:   dst_d = cand[2];
                default: dst_d = '0;
            endcase
        end
    end

    if (OUT_REG) begin : g_reg
        logic live_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                dst    <= '0;
                err    <= 1'b0;
                live_q <= 1'b0;
            end else begin
                dst    <= dst_d;
                err    <= bad;
                live_q <= 1'b1;
            end
        end

        // R9: a flagged result carries no data
        p_err_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
            err |-> (dst == '0));

        // R9: an unused width code is always flagged
        p_bad_elem_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (live_q && $past(elem_sel) == 2'd3) |-> err);

        // R7: nothing escapes above the 128-bit boundary
        p_vl128_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (live_q && $past(vl_sel) == 2'd0) |-> (dst[VMAX-1:128] == '0));

        // R7: nothing escapes above the 256-bit boundary
        p_vl256_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (live_q && $past(vl_sel) == 2'd1) |-> (dst[VMAX-1:256] == '0));

        // R5: an empty mask in zeroing mode clears everything
        p_zero_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (live_q && $past(mask_en && zeroing && mask == '0)) |-> (dst == '0));

        // R4: an empty mask in merging mode at full length returns old data
        p_merge_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (live_q && $past(mask_en && !zeroing && mask == '0 &&
                             elem_sel == 2'd1 && vl_sel == 2'd2))
            |-> (dst == $past(old_dst)));
    end else begin : g_comb
        assign dst = dst_d;
        assign err = bad;
    end

endmodule

// File: tb/test_vsra_unit.sv
`timescale 1ns/1ps
module test_vsra_unit;

    localparam int VMAX = 512;

    typedef struct packed {
        logic [1:0]  es;
        logic [1:0]  vs;
        logic        men;
        logic        zer;
        logic        ben;
        logic [31:0] mk;
        logic [63:0] p1;
        logic [63:0] p2;
        logic [63:0] cm;
        logic [63:0] sc;
    } vec_t;

    localparam int NROWS = 10;
    localparam vec_t TBL [NROWS] = '{
        '{2'd1, 2'd2, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 64'h8123_4567_F0F0_0F0F, 64'h0, 64'h0000_001F_0000_001F, 64'h0},
        '{2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 64'h8001_7FFE_C3A5_1234, 64'h0102_0304_0506_0708, 64'h000F_000F_000F_000F, 64'h0},
        '{2'd2, 2'd1, 1'b0, 1'b1, 1'b0, 32'h0000_0000, 64'hF00D_BEEF_0123_4567, 64'h0000_0000_0000_0011, 64'h0000_0000_0000_003F, 64'h0},
        '{2'd0, 2'd2, 1'b1, 1'b0, 1'b0, 32'hA5A5_3C3C, 64'h9876_5432_1FED_CBA9, 64'h1111_2222_3333_4444, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0},
        '{2'd1, 2'd1, 1'b1, 1'b1, 1'b0, 32'h0000_00C9, 64'hDEAD_0000_7FFF_FFFF, 64'h0000_0100_0000_0003, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0},
        '{2'd2, 2'd2, 1'b1, 1'b0, 1'b1, 32'h0000_005A, 64'hC000_1234_5678_9ABC, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0023},
        '{2'd1, 2'd0, 1'b1, 1'b1, 1'b1, 32'hFFFF_FFF5, 64'h8765_4321_0FED_CBA9, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_0000_0007},
        '{2'd1, 2'd2, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 64'hF123_4567_89AB_CDEF, 64'h0000_0010_0000_0001, 64'h0000_003F_0000_0021, 64'h0},
        '{2'd2, 2'd0, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 64'h8000_0000_0000_0001, 64'h0000_0000_0000_003D, 64'h0000_0000_0000_007F, 64'h0},
        '{2'd0, 2'd1, 1'b1, 1'b0, 1'b0, 32'hFFFF_0F0F, 64'hFEDC_0123_8000_7FFF, 64'h0001_0002_0003_0004, 64'h0013_0013_0013_0013, 64'h0}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [VMAX-1:0] src1 = '0;
    logic [VMAX-1:0] src2 = '0;
    logic [63:0]     bcst_scalar = '0;
    logic [VMAX-1:0] old_dst = '0;
    logic [31:0]     mask = '0;
    logic [1:0]      elem_sel = '0;
    logic [1:0]      vl_sel = '0;
    logic            mask_en = 1'b0;
    logic            zeroing = 1'b0;
    logic            bcst_en = 1'b0;
    logic [VMAX-1:0] dst;
    logic            err;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    vsra_unit i_vsra_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .src1        (src1),
        .src2        (src2),
        .bcst_scalar (bcst_scalar),
        .old_dst     (old_dst),
        .mask        (mask),
        .elem_sel    (elem_sel),
        .vl_sel      (vl_sel),
        .mask_en     (mask_en),
        .zeroing     (zeroing),
        .bcst_en     (bcst_en),
        .dst         (dst),
        .err         (err)
    );

    function automatic logic ref_err(logic [1:0] es, logic [1:0] vs, logic ben);
        return (es == 2'd3) || (vs == 2'd3) || (ben && es == 2'd0);
    endfunction

    // Bit-level model built from the requirements
    function automatic logic [VMAX-1:0] ref_dst(
        logic [1:0] es, logic [1:0] vs, logic men, logic zer, logic ben,
        logic [31:0] mk, logic [VMAX-1:0] a, logic [VMAX-1:0] b,
        logic [VMAX-1:0] o, logic [63:0] sc);
        logic [VMAX-1:0] r = '0;
        int ew, nl;
        if (ref_err(es, vs, ben)) return '0;
        ew = 16 << es;
        nl = (128 << vs) / ew;
        for (int j = 0; j < nl; j++) begin
            logic [63:0] cnt = '0;
            logic        sign = a[j*ew + ew - 1];
            if (ben) cnt = (ew == 32) ? {32'h0, sc[31:0]} : sc;
            else for (int t = 0; t < ew; t++) cnt[t] = b[j*ew + t];
            for (int t = 0; t < ew; t++) begin
                if (!men || mk[j]) begin
                    if (cnt >= 64'(ew)) r[j*ew + t] = sign;
                    else if (64'(t) + cnt < 64'(ew)) r[j*ew + t] = a[j*ew + t + int'(cnt)];
                    else r[j*ew + t] = sign;
                end else begin
                    r[j*ew + t] = zer ? 1'b0 : o[j*ew + t];
                end
            end
        end
        return r;
    endfunction

    task automatic chk_vec(string req, logic [VMAX-1:0] act, logic [VMAX-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic chk_bit(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%b exp=%b", req, act, exp);
        end
    endtask

    task automatic clear_in();
        src1 = '0; src2 = '0; bcst_scalar = '0; old_dst = '0; mask = '0;
        elem_sel = 2'd0; vl_sel = 2'd0; mask_en = 1'b0; zeroing = 1'b0; bcst_en = 1'b0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        clear_in();
        repeat (3) @(negedge clk);
        // R10: reset state
        chk_vec("R10 reset dst", dst, '0);
        chk_bit("R10 reset err", err, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R1 R2 R3 R4 R5 R6 R7 R8 against the model
        for (int n = 0; n < NROWS; n++) begin
            vec_t v = TBL[n];
            for (int i = 0; i < 8; i++) begin
                src1[i*64 +: 64]    = v.p1 ^ (64'(i) * 64'h1357_9BDF_2468_ACE1);
                src2[i*64 +: 64]    = (v.p2 + 64'(i) * 64'h0003_0005_0007_0009) & v.cm;
                old_dst[i*64 +: 64] = ~v.p1 + 64'(i);
            end
            elem_sel = v.es; vl_sel = v.vs; mask_en = v.men; zeroing = v.zer;
            bcst_en = v.ben; mask = v.mk; bcst_scalar = v.sc;
            step();
            chk_vec($sformatf("R1/R2/R3/R4/R5/R6/R7/R8 row %0d dst", n), dst,
                    ref_dst(v.es, v.vs, v.men, v.zer, v.ben, v.mk, src1, src2, old_dst, v.sc));
            chk_bit($sformatf("R9 row %0d err", n), err, 1'b0);
        end

        // R1: small counts on 16-bit lanes
        clear_in();
        src1[31:0] = 32'h4000_8000; src2[31:0] = 32'h000E_0003;
        step();
        chk_vec("R1 sign fill 16-bit", dst, {480'h0, 32'h0001_F000});

        // R2: count 0x8001 and count 16 on 16-bit lanes
        clear_in();
        src1[31:0] = 32'h8000_7FFF; src2[31:0] = 32'h0010_8001;
        step();
        chk_vec("R2 oversized 16-bit", dst, {480'h0, 32'hFFFF_0000});

        // R2: count 63 and count 64 on 64-bit lanes
        clear_in();
        elem_sel = 2'd2;
        src1[127:0] = {64'h4000_0000_0000_0000, 64'h8000_0000_0000_0000};
        src2[127:0] = {64'd64, 64'd63};
        step();
        chk_vec("R2 boundary 64-bit", dst, {384'h0, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF});

        // R8: broadcast uses low half only for 32-bit lanes; src2 ignored
        clear_in();
        elem_sel = 2'd1; bcst_en = 1'b1; bcst_scalar = 64'hFFFF_FFFF_0000_0004;
        src1 = {16{32'h8000_0010}}; src2 = '1;
        step();
        chk_vec("R8 broadcast 32-bit", dst, {384'h0, {4{32'hF800_0001}}});

        // R7: masked-off lanes merge, lanes above 128 bits stay zero
        clear_in();
        elem_sel = 2'd1; mask_en = 1'b1; mask = 32'hFFFF_FFF0; old_dst = '1; src1 = '1;
        step();
        chk_vec("R7 above length", dst, {384'h0, {128{1'b1}}});

        // R6: mask disabled ignores empty mask and zeroing
        clear_in();
        elem_sel = 2'd1; zeroing = 1'b1; src1 = {16{32'h0000_0100}}; src2 = {16{32'd4}};
        step();
        chk_vec("R6 mask off", dst, {384'h0, {4{32'h0000_0010}}});

        // R10: output holds until the next edge
        clear_in();
        src1[31:0] = 32'h4000_8000; src2[31:0] = 32'h000E_0003;
        #1;
        chk_vec("R10 holds before edge", dst, {384'h0, {4{32'h0000_0010}}});
        step();
        chk_vec("R10 new after edge", dst, {480'h0, 32'h0001_F000});

        // R9: illegal combinations
        clear_in();
        elem_sel = 2'd3; src1 = '1;
        step();
        chk_bit("R9 bad width err", err, 1'b1);
        chk_vec("R9 bad width dst", dst, '0);

        clear_in();
        bcst_en = 1'b1; elem_sel = 2'd0; src1 = '1;
        step();
        chk_bit("R9 broadcast 16-bit err", err, 1'b1);
        chk_vec("R9 broadcast 16-bit dst", dst, '0);

        clear_in();
        vl_sel = 2'd3; elem_sel = 2'd1; src1 = '1;
        step();
        chk_bit("R9 bad length err", err, 1'b1);

        // R10: reset clears a live result
        clear_in();
        src1 = '1;
        step();
        rst_n = 1'b0;
        #1;
        chk_vec("R10 reset clears dst", dst, '0);
        chk_bit("R10 reset clears err", err, 1'b0);

        finish_run();
    end

endmodule